// File: doc/BRIEF.md
# Receive FIFO Time-out Detector

This block watches a receive FIFO and a companion status FIFO from the outside. It keeps neither FIFO's storage. It counts microsecond ticks since the receiver last loaded a byte or since the FIFO was last read. When data has stayed in the receive FIFO longer than the limit for the current mode, it latches a time-out. The latched time-out drives a receive interrupt, a receive DMA request, or both, according to the enable inputs. It also records whether the FIFO level was under the service threshold at that moment, so that software can tell a time-out from a threshold event.

A second detector of the same kind serves the status FIFO. It runs only in the two high-speed infrared modes and drives an interrupt of its own. Each latched time-out stays set until the FIFO that caused it is read, or until that FIFO empties.

Top module: `rx_fifo_timeout`

## Requirements
- R1: After reset, `rx_irq_o`, `rx_dma_o`, `rx_below_o` and `st_irq_o` are all 0.
- R2: A receive time-out never occurs while `rx_count_i` is 0. If the count falls to 0, any pending time-out is cleared on the next clock edge.
- R3: In the high-speed modes (`mode_i` = 2'b10 or 2'b11), a receive time-out latches only after more than `HS_LIMIT` ticks since the last restart. Exactly `HS_LIMIT` ticks raise nothing.
- R4: In the other modes (`mode_i` = 2'b00 or 2'b01), the receive limit is `LS_LIMIT` ticks. More than `HS_LIMIT` but no more than `LS_LIMIT` ticks raise nothing.
- R5: A pulse on `rx_wr_i` restarts the elapsed-tick count from zero.
- R6: `rx_irq_o` is high exactly while a receive time-out is latched and `rx_ie_i` is 1.
- R7: `rx_dma_o` is high only while a receive time-out is latched and both `dma_en_i` and `ext_i` are 1.
- R8: `rx_below_o` is set together with a time-out when `rx_count_i` < `rx_thr_i` at that moment. It stays 0 if the level was at or above the threshold. It clears together with the time-out.
- R9: A latched receive time-out holds until a pulse on `rx_rd_i`. The read clears the time-out on the next edge and also restarts the tick count.
- R10: A status time-out (more than `HS_LIMIT` ticks with `st_count_i` nonzero) drives `st_irq_o` when `st_ie_i` is 1, in the high-speed modes only. In the other modes `st_irq_o` is 0 and the status detector is cleared.
- R11: A pulse on `st_rd_i` clears a latched status time-out and restarts its tick count. A pulse on `st_wr_i` restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Link mode: 00 UART, 01 slow IR, 10 medium IR, 11 fast IR |
| ext_i | input | 1 | Extended register mode active |
| rx_ie_i | input | 1 | Receive data interrupt enable |
| dma_en_i | input | 1 | Receive DMA enable |
| st_ie_i | input | 1 | Status FIFO time-out interrupt enable |
| tick_i | input | 1 | One-cycle pulse each microsecond |
| rx_count_i | input | CNT_W | Receive FIFO level |
| rx_thr_i | input | CNT_W | Receive service threshold |
| rx_wr_i | input | 1 | Receiver loaded a byte into the receive FIFO |
| rx_rd_i | input | 1 | Receive FIFO read by CPU or DMA |
| st_count_i | input | ST_CNT_W | Status FIFO level |
| st_wr_i | input | 1 | Entry loaded into the status FIFO |
| st_rd_i | input | 1 | Status FIFO read |
| rx_irq_o | output | 1 | Receive time-out interrupt |
| rx_dma_o | output | 1 | Receive time-out DMA request |
| rx_below_o | output | 1 | Time-out occurred below threshold |
| st_irq_o | output | 1 | Status FIFO time-out interrupt |

## Verification
The checker holds on every cycle the rules that need no count of ticks. An empty FIFO or a read leaves the outputs low on the next cycle. The DMA request never appears without both of its enables. The below-threshold flag only rises after a level under the threshold. The status interrupt stays silent outside the high-speed modes. Only the bench scenarios can show the exact tick boundaries: one tick short of either limit, the first tick past it, a restart part-way through a window, and holding of the latch across idle cycles.

// File: rtl/rx_fifo_timeout_pkg.sv
package rx_fifo_timeout_pkg;
  typedef enum logic [1:0] {
    MODE_UART = 2'b00,
    MODE_SIR  = 2'b01,
    MODE_MIR  = 2'b10,
    MODE_FIR  = 2'b11
  } link_mode_e;

  function automatic logic mode_is_fast(link_mode_e m);
    return (m == MODE_MIR) || (m == MODE_FIR);
  endfunction
endpackage

// File: rtl/rx_fifo_timeout_timer.sv
// Saturating tick counter; expired once count exceeds limit.
module rx_fifo_timeout_timer #(
  parameter int TMR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             tick_i,
  input  logic [TMR_W-1:0] limit_i,
  output logic             expired_o
);
  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (restart_i)                  cnt_q <= '0;
    else if (tick_i && cnt_q <= limit_i) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = cnt_q > limit_i;
endmodule

// File: rtl/rx_fifo_timeout_flag.sv
// Sticky time-out flag; clear wins over set.
module rx_fifo_timeout_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic set_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_o <= 1'b0;
    else if (clear_i) flag_o <= 1'b0;
    else if (set_i)   flag_o <= 1'b1;
  end
endmodule

// File: rtl/rx_fifo_timeout.sv
module rx_fifo_timeout
  import rx_fifo_timeout_pkg::*;
#(
  parameter int CNT_W    = 5,
  parameter int ST_CNT_W = 4,
  parameter int HS_LIMIT = 64,
  parameter int LS_LIMIT = 160
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          mode_i,
  input  logic                ext_i,
  input  logic                rx_ie_i,
  input  logic                dma_en_i,
  input  logic                st_ie_i,
  input  logic                tick_i,
  input  logic [CNT_W-1:0]    rx_count_i,
  input  logic [CNT_W-1:0]    rx_thr_i,
  input  logic                rx_wr_i,
  input  logic                rx_rd_i,
  input  logic [ST_CNT_W-1:0] st_count_i,
  input  logic                st_wr_i,
  input  logic                st_rd_i,
  output logic                rx_irq_o,
  output logic                rx_dma_o,
  output logic                rx_below_o,
  output logic                st_irq_o
);
  localparam int MAX_LIMIT = (HS_LIMIT > LS_LIMIT) ? HS_LIMIT : LS_LIMIT;
  localparam int TMR_W     = $clog2(MAX_LIMIT + 2);
  localparam logic [TMR_W-1:0] HS_LIM = TMR_W'(HS_LIMIT);
  localparam logic [TMR_W-1:0] LS_LIM = TMR_W'(LS_LIMIT);

  logic fast;
  assign fast = mode_is_fast(link_mode_e'(mode_i));

  // receive path
  logic             rx_empty, rx_restart, rx_clear, rx_expired, rx_to;
  logic [TMR_W-1:0] rx_limit;

  assign rx_empty   = (rx_count_i == '0);
  assign rx_limit   = fast ? HS_LIM : LS_LIM;
  assign rx_restart = rx_wr_i | rx_rd_i | rx_empty;
  assign rx_clear   = rx_rd_i | rx_empty;

  rx_fifo_timeout_timer #(.TMR_W(TMR_W)) i_rx_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (rx_restart),
    .tick_i    (tick_i),
    .limit_i   (rx_limit),
    .expired_o (rx_expired)
  );

  rx_fifo_timeout_flag i_rx_flag (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (rx_clear),
    .set_i   (rx_expired),
    .flag_o  (rx_to)
  );

  // below-threshold mark captured when the time-out first fires
  logic below_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   below_q <= 1'b0;
    else if (rx_clear)                             below_q <= 1'b0;
    else if (rx_expired && !rx_to &&
             (rx_count_i < rx_thr_i))              below_q <= 1'b1;
  end

  // status path, live only in fast modes
  logic st_empty, st_restart, st_clear, st_expired, st_to;
  assign st_empty   = (st_count_i == '0);
  assign st_clear   = st_rd_i | st_empty | !fast;
  assign st_restart = st_wr_i | st_clear;

  rx_fifo_timeout_timer #(.TMR_W(TMR_W)) i_st_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (st_restart),
    .tick_i    (tick_i),
    .limit_i   (HS_LIM),
    .expired_o (st_expired)
  );

  rx_fifo_timeout_flag i_st_flag (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (st_clear),
    .set_i   (st_expired),
    .flag_o  (st_to)
  );

  assign rx_irq_o   = rx_to & rx_ie_i;
  assign rx_dma_o   = rx_to & dma_en_i & ext_i;
  assign rx_below_o = below_q;
  assign st_irq_o   = st_to & st_ie_i & fast;
endmodule

// File: rtl/rx_fifo_timeout_chk.sv
module rx_fifo_timeout_chk #(
  parameter int CNT_W    = 5,
  parameter int ST_CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       mode_i,
  input logic             ext_i,
  input logic             dma_en_i,
  input logic [CNT_W-1:0] rx_count_i,
  input logic [CNT_W-1:0] rx_thr_i,
  input logic             rx_rd_i,
  input logic             st_rd_i,
  input logic             rx_irq_o,
  input logic             rx_dma_o,
  input logic             rx_below_o,
  input logic             st_irq_o
);
  a_r2_empty_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_count_i == '0) |=> (!rx_irq_o && !rx_dma_o && !rx_below_o));

  a_r7_dma_enables: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_dma_o |-> (dma_en_i && ext_i));

  a_r8_below_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_below_o) |-> $past(rx_count_i < rx_thr_i));

  a_r9_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_rd_i |=> (!rx_irq_o && !rx_dma_o && !rx_below_o));

  a_r10_slow_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i[1] |-> !st_irq_o);

  a_r11_st_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_rd_i |=> !st_irq_o);
endmodule

bind rx_fifo_timeout rx_fifo_timeout_chk #(.CNT_W(CNT_W), .ST_CNT_W(ST_CNT_W)) i_chk (.*);

// File: tb/test_rx_fifo_timeout.sv
`timescale 1ns/1ps
module test_rx_fifo_timeout;
  localparam int CNT_W = 5, ST_CNT_W = 4, HS = 64, LS = 160;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic ext_i = 0, rx_ie_i = 0, dma_en_i = 0, st_ie_i = 0, tick_i = 0;
  logic [CNT_W-1:0] rx_count_i = '0, rx_thr_i = '0;
  logic rx_wr_i = 0, rx_rd_i = 0, st_wr_i = 0, st_rd_i = 0;
  logic [ST_CNT_W-1:0] st_count_i = '0;
  logic rx_irq_o, rx_dma_o, rx_below_o, st_irq_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  rx_fifo_timeout #(.CNT_W(CNT_W), .ST_CNT_W(ST_CNT_W), .HS_LIMIT(HS), .LS_LIMIT(LS))
  i_rx_fifo_timeout (.*);

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1; @(negedge clk_i); tick_i = 0; @(negedge clk_i);
    end
  endtask

  task automatic rx_write(int cnt);
    rx_wr_i = 1; rx_count_i = CNT_W'(cnt); @(negedge clk_i); rx_wr_i = 0;
  endtask

  task automatic rx_read(int cnt);
    rx_rd_i = 1; rx_count_i = CNT_W'(cnt); @(negedge clk_i); rx_rd_i = 0;
  endtask

  task automatic t_reset();
    chk("R1 rx_irq", rx_irq_o, 0);
    chk("R1 rx_dma", rx_dma_o, 0);
    chk("R1 below", rx_below_o, 0);
    chk("R1 st_irq", st_irq_o, 0);
  endtask

  task automatic t_fast_limit();
    mode_i = 2'b10; rx_ie_i = 1; rx_thr_i = 8;
    rx_write(3);
    ticks(HS); idle(2);
    chk("R3 at limit", rx_irq_o, 0);
    ticks(1); idle(2);
    chk("R3 past limit", rx_irq_o, 1);
    chk("R6 irq", rx_irq_o, 1);
    chk("R8 below set", rx_below_o, 1);
    idle(10);
    chk("R9 held", rx_irq_o, 1);
    rx_read(2);
    chk("R9 read clears", rx_irq_o, 0);
    chk("R8 below clears", rx_below_o, 0);
    ticks(HS); idle(2);
    chk("R9 read restarts", rx_irq_o, 0);
    ticks(1); idle(2);
    chk("R9 refires", rx_irq_o, 1);
    rx_ie_i = 0; #1;
    chk("R6 ie off", rx_irq_o, 0);
    rx_ie_i = 1;
    rx_read(1);
  endtask

  task automatic t_restart();
    rx_write(2);
    ticks(40);
    rx_write(3);
    ticks(40); idle(2);
    chk("R5 restart", rx_irq_o, 0);
    ticks(25); idle(2);
    chk("R5 after restart", rx_irq_o, 1);
    rx_read(2);
  endtask

  task automatic t_slow_limit();
    mode_i = 2'b00;
    rx_write(3);
    ticks(HS + 1); idle(2);
    chk("R4 beyond fast", rx_irq_o, 0);
    ticks(LS - HS - 1); idle(2);
    chk("R4 at limit", rx_irq_o, 0);
    ticks(1); idle(2);
    chk("R4 past limit", rx_irq_o, 1);
    rx_read(2);
    mode_i = 2'b11;
  endtask

  task automatic t_empty();
    rx_count_i = '0;
    ticks(HS + 10); idle(2);
    chk("R2 empty", rx_irq_o, 0);
    rx_write(1);
    ticks(HS + 1); idle(2);
    chk("R2 pending", rx_irq_o, 1);
    rx_count_i = '0; idle(1);
    chk("R2 empty clears", rx_irq_o, 0);
    chk("R2 below clears", rx_below_o, 0);
  endtask

  task automatic t_dma();
    rx_ie_i = 0; dma_en_i = 1; ext_i = 0;
    rx_write(3);
    ticks(HS + 1); idle(2);
    chk("R7 no irq", rx_irq_o, 0);
    chk("R7 ext off", rx_dma_o, 0);
    ext_i = 1; #1;
    chk("R7 dma", rx_dma_o, 1);
    dma_en_i = 0; #1;
    chk("R7 dma en off", rx_dma_o, 0);
    dma_en_i = 1;
    rx_read(2);
    chk("R9 dma cleared", rx_dma_o, 0);
    rx_ie_i = 1; dma_en_i = 0; ext_i = 0;
  endtask

  task automatic t_above();
    rx_thr_i = 8;
    rx_write(10);
    ticks(HS + 1); idle(2);
    chk("R8 above irq", rx_irq_o, 1);
    chk("R8 above no below", rx_below_o, 0);
    rx_read(0);
  endtask

  task automatic t_status();
    rx_count_i = '0; mode_i = 2'b00; st_ie_i = 1;
    st_count_i = 2; st_wr_i = 1; @(negedge clk_i); st_wr_i = 0;
    ticks(HS + 20); idle(2);
    chk("R10 slow quiet", st_irq_o, 0);
    mode_i = 2'b10;
    st_wr_i = 1; @(negedge clk_i); st_wr_i = 0;
    ticks(HS); idle(2);
    chk("R10 at limit", st_irq_o, 0);
    ticks(1); idle(2);
    chk("R10 fires", st_irq_o, 1);
    st_ie_i = 0; #1;
    chk("R10 ie off", st_irq_o, 0);
    st_ie_i = 1;
    st_rd_i = 1; st_count_i = 1; @(negedge clk_i); st_rd_i = 0;
    chk("R11 read clears", st_irq_o, 0);
    ticks(HS); idle(2);
    chk("R11 read restarts", st_irq_o, 0);
    ticks(1); idle(2);
    chk("R11 refires", st_irq_o, 1);
    mode_i = 2'b01; idle(1);
    chk("R10 mode leave", st_irq_o, 0);
    mode_i = 2'b11; idle(2);
    chk("R10 stays cleared", st_irq_o, 0);
  endtask

  initial begin
    idle(3);
    t_reset();
    rst_ni = 1;
    idle(2);
    t_reset();
    t_fast_limit();
    t_restart();
    t_slow_limit();
    t_empty();
    t_dma();
    t_above();
    t_status();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule